// File: doc/BRIEF.md
# USB Host Frame Timer

This block keeps the frame clock of a USB host controller. A 14-bit down-counter tracks how many bit times remain in the current frame. It steps once per bit-time enable pulse and, on reaching zero, reloads from a programmable interval. That reload is the frame boundary. At the boundary a 16-bit frame number advances. A sequencer then asks the token transmitter for a start-of-frame token carrying the new number. Next it writes the same number to the shared host memory area over a valid/ready write port. Only when that write is accepted does it raise a start-of-frame status flag and let the list processor fetch the frame's first endpoint descriptor.

A periodic-start threshold marks the point in the frame after which periodic list work may begin. Software reaches the interval, the threshold and the status flag through a small 32-bit register port. It can also read the remaining count and the frame number there. Counting happens only while the host is operational. A boundary that arrives while a sequence is still running is remembered, and one more sequence follows with the frame number current at its start.

The sequencer has three states:
- Idle: no work, and descriptor fetch is permitted.
- Announce: the start-of-frame request is raised.
- Store: the shared-memory write is pending.

Its transitions are:
- Idle to Announce on a boundary.
- Announce to Store, always after one cycle.
- Store back to Announce when the write is accepted and a boundary is pending or arriving.
- Store to Idle when the write is accepted and nothing is pending.
- Store stays in Store while the write is not accepted.

Top module: `usb_frame_timer`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) sets the remaining count to 0, the frame number to 0, the interval register to 11999, the periodic-start register to 10799, and clears the status flag, periodic enable and pending boundary. The sequencer goes to Idle, so desc_fetch_ok_o is 1 and sof_req_o and mem_wr_valid_o are 0.
- R2: While run_i is 1, each edge with bit_tick_i high decrements the remaining count. When the count is 0 it instead reloads from the interval register and the frame number advances by one: that edge is the frame boundary. While run_i is 0, neither the count nor the frame number changes.
- R3: The frame number wraps from 0xFFFF to 0x0000.
- R4: In the cycle after a boundary taken from Idle, sof_req_o is 1 for exactly one cycle, and sof_num_o equals the advanced frame number.
- R5: In the cycle after sof_req_o, mem_wr_valid_o is 1 and mem_wr_data_o carries the same number. Both hold stable until a cycle with mem_wr_ready_i high.
- R6: desc_fetch_ok_o is 0 from the cycle after a boundary until the cycle after the write is accepted.
- R7: sof_flag_o rises in the cycle after the write is accepted, never earlier. Writing a 1 to bit 0 of register address 4 clears it, and a set in the same cycle wins over the clear.
- R8: periodic_en_o rises in the cycle after an edge at which run_i is 1 and the remaining count is at most the periodic-start value. It is cleared by a frame boundary, which wins over the set.
- R9: Register map for reads on reg_rdata_o, all fields right-aligned and all other bits 0:
  - address 0: interval (14 bits, read/write)
  - address 1: remaining count (read-only)
  - address 2: frame number (read-only; writes have no effect)
  - address 3: periodic start (14 bits, read/write)
  - address 4: status flag in bit 0
  - any other address reads 0
- R10: A boundary during Announce or Store is held as pending. On acceptance of the write, a pending or simultaneous boundary restarts Announce with the frame number current at that restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Host is in the operational state |
| bit_tick_i | input | 1 | One pulse per bit time |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sof_req_o | output | 1 | Start-of-frame token request |
| sof_num_o | output | 16 | Frame number for the token |
| mem_wr_valid_o | output | 1 | Shared-memory write request |
| mem_wr_data_o | output | 16 | Frame number to store |
| mem_wr_ready_i | input | 1 | Shared-memory write accepted |
| desc_fetch_ok_o | output | 1 | Descriptor fetch permitted |
| periodic_en_o | output | 1 | Periodic list work permitted |
| sof_flag_o | output | 1 | Start-of-frame status flag |

## Verification
A wrong remaining count appears at register address 1 in the same cycle. It also moves the next boundary, and with it sof_req_o and the frame number, within one frame. A corrupted frame number or pending bit shows on sof_num_o, mem_wr_data_o or an extra or missing Announce within a few cycles of the next boundary. A sequencer out of step breaks the request, write, flag order at once. A reference model updated every clock catches any of these on the first differing cycle.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_ANNOUNCE = 2'd1,
        SEQ_STORE    = 2'd2
    } seq_state_t;

    localparam int REG_ADDR_W = 3;
    localparam logic [REG_ADDR_W-1:0] ADDR_INTERVAL = 3'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_REMAIN   = 3'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_FRAME    = 3'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_PSTART   = 3'd3;
    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS   = 3'd4;
endpackage

// File: rtl/ft_frame_counter.sv
module ft_frame_counter #(
    parameter int CNT_W = 14,
    parameter int FN_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] interval_i,
    input  logic [CNT_W-1:0] pstart_i,
    output logic [CNT_W-1:0] remain_o,
    output logic [FN_W-1:0]  fn_o,
    output logic [FN_W-1:0]  fn_adv_o,
    output logic             boundary_o,
    output logic             periodic_en_o
);
    logic [CNT_W-1:0] remain_q;
    logic [FN_W-1:0]  fn_q;
    logic             pe_q;

    assign boundary_o    = run_i && tick_i && (remain_q == '0);
    assign fn_adv_o      = fn_q + 1'b1;
    assign remain_o      = remain_q;
    assign fn_o          = fn_q;
    assign periodic_en_o = pe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            fn_q     <= '0;
            pe_q     <= 1'b0;
        end else begin
            if (run_i && tick_i) begin
                remain_q <= boundary_o ? interval_i : remain_q - 1'b1;
            end
            if (boundary_o) begin
                fn_q <= fn_adv_o;
            end
            if (boundary_o) begin
                pe_q <= 1'b0;
            end else if (run_i && (remain_q <= pstart_i)) begin
                pe_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ft_sof_seq.sv
module ft_sof_seq
    import usb_ft_pkg::*;
#(
    parameter int FN_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boundary_i,
    input  logic [FN_W-1:0] fn_i,
    input  logic [FN_W-1:0] fn_adv_i,
    input  logic            ready_i,
    output logic            sof_req_o,
    output logic [FN_W-1:0] sof_num_o,
    output logic            valid_o,
    output logic [FN_W-1:0] data_o,
    output logic            fetch_ok_o,
    output logic            accept_o
);
    seq_state_t      state_q, state_d;
    logic            pend_q;
    logic [FN_W-1:0] num_q;
    logic            accept;
    logic            restart;

    assign accept  = (state_q == SEQ_STORE) && ready_i;
    assign restart = accept && (pend_q || boundary_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:     if (boundary_i) state_d = SEQ_ANNOUNCE;
            SEQ_ANNOUNCE: state_d = SEQ_STORE;
            SEQ_STORE: begin
                if (restart)     state_d = SEQ_ANNOUNCE;
                else if (accept) state_d = SEQ_IDLE;
            end
            default:      state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            pend_q  <= 1'b0;
            num_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && boundary_i) begin
                num_q <= fn_adv_i;
            end else if (restart) begin
                num_q <= boundary_i ? fn_adv_i : fn_i;
            end
            if (accept) begin
                pend_q <= 1'b0;
            end else if (state_q != SEQ_IDLE && boundary_i) begin
                pend_q <= 1'b1;
            end
        end
    end

    always_comb begin
        sof_req_o  = (state_q == SEQ_ANNOUNCE);
        valid_o    = (state_q == SEQ_STORE);
        fetch_ok_o = (state_q == SEQ_IDLE);
        sof_num_o  = num_q;
        data_o     = num_q;
        accept_o   = accept;
    end
endmodule

// File: rtl/ft_regs.sv
module ft_regs
    import usb_ft_pkg::*;
#(
    parameter int          CNT_W        = 14,
    parameter int          FN_W         = 16,
    parameter int          DATA_W       = 32,
    parameter int unsigned INTERVAL_RST = 11999,
    parameter int unsigned PSTART_RST   = 10799
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic                  wr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic                  accept_i,
    input  logic [CNT_W-1:0]      remain_i,
    input  logic [FN_W-1:0]       fn_i,
    output logic [CNT_W-1:0]      interval_o,
    output logic [CNT_W-1:0]      pstart_o,
    output logic                  flag_o,
    output logic [DATA_W-1:0]     rdata_o
);
    logic [CNT_W-1:0] interval_q;
    logic [CNT_W-1:0] pstart_q;
    logic             flag_q;
    logic             unused_wbits;

    assign unused_wbits = ^wdata_i[DATA_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            interval_q <= CNT_W'(INTERVAL_RST);
            pstart_q   <= CNT_W'(PSTART_RST);
            flag_q     <= 1'b0;
        end else begin
            if (wr_i && addr_i == ADDR_INTERVAL) interval_q <= wdata_i[CNT_W-1:0];
            if (wr_i && addr_i == ADDR_PSTART)   pstart_q   <= wdata_i[CNT_W-1:0];
            if (accept_i) begin
                flag_q <= 1'b1;
            end else if (wr_i && addr_i == ADDR_STATUS && wdata_i[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr_i)
            ADDR_INTERVAL: rdata_o = DATA_W'(interval_q);
            ADDR_REMAIN:   rdata_o = DATA_W'(remain_i);
            ADDR_FRAME:    rdata_o = DATA_W'(fn_i);
            ADDR_PSTART:   rdata_o = DATA_W'(pstart_q);
            ADDR_STATUS:   rdata_o = DATA_W'(flag_q);
            default:       rdata_o = '0;
        endcase
    end

    assign interval_o = interval_q;
    assign pstart_o   = pstart_q;
    assign flag_o     = flag_q;
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
    import usb_ft_pkg::*;
#(
    parameter int          CNT_W        = 14,
    parameter int          FN_W         = 16,
    parameter int          DATA_W       = 32,
    parameter int unsigned INTERVAL_RST = 11999,
    parameter int unsigned PSTART_RST   = 10799
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_i,
    input  logic                  bit_tick_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    output logic                  sof_req_o,
    output logic [FN_W-1:0]       sof_num_o,
    output logic                  mem_wr_valid_o,
    output logic [FN_W-1:0]       mem_wr_data_o,
    input  logic                  mem_wr_ready_i,
    output logic                  desc_fetch_ok_o,
    output logic                  periodic_en_o,
    output logic                  sof_flag_o
);
    logic [CNT_W-1:0] interval_q;
    logic [CNT_W-1:0] pstart_q;
    logic [CNT_W-1:0] remain_q;
    logic [FN_W-1:0]  fn_q;
    logic [FN_W-1:0]  fn_adv;
    logic             boundary;
    logic             accept;

    ft_frame_counter #(.CNT_W(CNT_W), .FN_W(FN_W)) u_cnt (
        .clk(clk), .rst(rst), .run_i(run_i), .tick_i(bit_tick_i),
        .interval_i(interval_q), .pstart_i(pstart_q),
        .remain_o(remain_q), .fn_o(fn_q), .fn_adv_o(fn_adv),
        .boundary_o(boundary), .periodic_en_o(periodic_en_o)
    );

    ft_sof_seq #(.FN_W(FN_W)) u_seq (
        .clk(clk), .rst(rst), .boundary_i(boundary), .fn_i(fn_q),
        .fn_adv_i(fn_adv), .ready_i(mem_wr_ready_i),
        .sof_req_o(sof_req_o), .sof_num_o(sof_num_o),
        .valid_o(mem_wr_valid_o), .data_o(mem_wr_data_o),
        .fetch_ok_o(desc_fetch_ok_o), .accept_o(accept)
    );

    ft_regs #(
        .CNT_W(CNT_W), .FN_W(FN_W), .DATA_W(DATA_W),
        .INTERVAL_RST(INTERVAL_RST), .PSTART_RST(PSTART_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
        .wdata_i(reg_wdata_i), .accept_i(accept), .remain_i(remain_q),
        .fn_i(fn_q), .interval_o(interval_q), .pstart_o(pstart_q),
        .flag_o(sof_flag_o), .rdata_o(reg_rdata_o)
    );
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
    parameter int CNT_W = 14,
    parameter int FN_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sof_req_o,
    input logic [FN_W-1:0]  sof_num_o,
    input logic             mem_wr_valid_o,
    input logic [FN_W-1:0]  mem_wr_data_o,
    input logic             mem_wr_ready_i,
    input logic             desc_fetch_ok_o,
    input logic             sof_flag_o,
    input logic             boundary,
    input logic [FN_W-1:0]  fn_q,
    input logic [CNT_W-1:0] remain_q,
    input logic [CNT_W-1:0] interval_q
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> desc_fetch_ok_o && !sof_req_o && !mem_wr_valid_o && !sof_flag_o);

    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        boundary |=> remain_q == $past(interval_q));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        boundary && (fn_q == {FN_W{1'b1}}) |=> fn_q == '0);

    assert_sof_on_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        boundary && desc_fetch_ok_o |=> sof_req_o && sof_num_o == fn_q);

    assert_store_follows_sof_R5: assert property (@(posedge clk) disable iff (rst)
        sof_req_o |=> mem_wr_valid_o && mem_wr_data_o == $past(sof_num_o));

    assert_store_holds_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid_o && !mem_wr_ready_i |=> mem_wr_valid_o && $stable(mem_wr_data_o));

    assert_fetch_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid_o || sof_req_o) |-> !desc_fetch_ok_o);

    assert_flag_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sof_flag_o) |-> $past(mem_wr_valid_o && mem_wr_ready_i));
endmodule

bind usb_frame_timer ft_checker #(.CNT_W(CNT_W), .FN_W(FN_W)) u_ft_checker (.*);

// File: tb/test_usb_frame_timer.sv
module test_usb_frame_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 1'b0;
    logic        bit_tick_i = 1'b0;
    logic [2:0]  reg_addr_i = 3'd0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = 32'd0;
    logic [31:0] reg_rdata_o;
    logic        sof_req_o;
    logic [15:0] sof_num_o;
    logic        mem_wr_valid_o;
    logic [15:0] mem_wr_data_o;
    logic        mem_wr_ready_i = 1'b1;
    logic        desc_fetch_ok_o;
    logic        periodic_en_o;
    logic        sof_flag_o;

    usb_frame_timer i_usb_frame_timer (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit done = 0;
    string rd_tag = "R9";

    // behavioural reference model
    int m_rem = 0, m_fn = 0, m_int = 11999, m_ps = 10799;
    int m_st = 0;
    bit m_pend = 0, m_flag = 0, m_pe = 0;
    int m_num = 0;

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_rem = 0; m_fn = 0; m_int = 11999; m_ps = 10799;
            m_st = 0; m_pend = 0; m_flag = 0; m_pe = 0; m_num = 0;
        end else begin
            bit b, acc;
            int nfn;
            b = run_i && bit_tick_i && (m_rem == 0);
            acc = (m_st == 2) && mem_wr_ready_i;
            nfn = b ? ((m_fn + 1) % 65536) : m_fn;
            if (b) m_pe = 0;
            else if (run_i && m_rem <= m_ps) m_pe = 1;
            if (run_i && bit_tick_i) m_rem = b ? m_int : m_rem - 1;
            case (m_st)
                0: if (b) begin m_st = 1; m_num = nfn; end
                1: begin m_st = 2; if (b) m_pend = 1; end
                default: begin
                    if (acc) begin
                        if (m_pend || b) begin m_st = 1; m_num = nfn; end
                        else m_st = 0;
                        m_pend = 0;
                    end else if (b) m_pend = 1;
                end
            endcase
            if (acc) m_flag = 1;
            else if (reg_wr_i && reg_addr_i == 3'd4 && reg_wdata_i[0]) m_flag = 0;
            if (reg_wr_i && reg_addr_i == 3'd0) m_int = int'(reg_wdata_i[13:0]);
            if (reg_wr_i && reg_addr_i == 3'd3) m_ps = int'(reg_wdata_i[13:0]);
            m_fn = nfn;
        end
    end

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_int);
            3'd1: return 32'(m_rem);
            3'd2: return 32'(m_fn);
            3'd3: return 32'(m_ps);
            3'd4: return 32'(m_flag);
            default: return 32'd0;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (started && !rst && !done) begin
            cmp("R4", "sof_req", 32'(sof_req_o), 32'(m_st == 1));
            cmp("R4", "sof_num", 32'(sof_num_o), 32'(m_num));
            cmp("R5", "wr_valid", 32'(mem_wr_valid_o), 32'(m_st == 2));
            if (m_st == 2) cmp("R5", "wr_data", 32'(mem_wr_data_o), 32'(m_num));
            cmp("R6", "fetch_ok", 32'(desc_fetch_ok_o), 32'(m_st == 0));
            cmp("R7", "flag", 32'(sof_flag_o), 32'(m_flag));
            cmp("R8", "periodic_en", 32'(periodic_en_o), 32'(m_pe));
            cmp(rd_tag, "rdata", reg_rdata_o, model_rd(reg_addr_i));
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr_i = a;
        #1;
        cmp(tag, "reg read", reg_rdata_o, exp);
    endtask

    task automatic finish_run;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] hold_fn;
        step(3);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        rd_chk("R1", 3'd0, 32'd11999);
        rd_chk("R1", 3'd3, 32'd10799);
        rd_chk("R1", 3'd1, 32'd0);
        rd_chk("R1", 3'd2, 32'd0);
        rd_chk("R1", 3'd4, 32'd0);
        cmp("R1", "fetch_ok", 32'(desc_fetch_ok_o), 32'd1);
        // R9 frame number write ignored, unmapped address reads 0
        wr_reg(3'd2, 32'h0000ABCD);
        rd_chk("R9", 3'd2, 32'd0);
        rd_chk("R9", 3'd6, 32'd0);
        wr_reg(3'd0, 32'hFFFF0005);
        rd_chk("R9", 3'd0, 32'd5);
        wr_reg(3'd3, 32'd2);
        // R2 first boundary on the first tick while running
        @(negedge clk); run_i = 1'b1; bit_tick_i = 1'b1;
        @(negedge clk); bit_tick_i = 1'b0; reg_addr_i = 3'd2;
        #1 cmp("R2", "fn after first boundary", reg_rdata_o, 32'd1);
        rd_chk("R2", 3'd1, 32'd5);
        bit_tick_i = 1'b1;
        step(40);
        // R5 R6 write held off
        mem_wr_ready_i = 1'b0;
        step(20);
        mem_wr_ready_i = 1'b1;
        step(3);
        // R7 clear by writing 1 at address 4
        wr_reg(3'd4, 32'd1);
        rd_chk("R7", 3'd4, 32'(m_flag));
        // R2 no counting while not running
        @(negedge clk); run_i = 1'b0; reg_addr_i = 3'd2;
        #1 hold_fn = reg_rdata_o;
        step(12);
        #1 cmp("R2", "fn held while stopped", reg_rdata_o, hold_fn);
        run_i = 1'b1;
        // irregular ticks
        for (int i = 0; i < 90; i++) begin
            @(negedge clk); bit_tick_i = (i % 3 == 0);
        end
        bit_tick_i = 1'b1;
        // R10 boundary every tick with stalling writes
        wr_reg(3'd0, 32'd0);
        rd_tag = "R10";
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); mem_wr_ready_i = (i % 4 != 1);
        end
        mem_wr_ready_i = 1'b1;
        // R3 wrap of the frame number
        rd_tag = "R3";
        reg_addr_i = 3'd2;
        step(65600);
        cmp("R3", "fn passed wrap", 32'(m_fn < 200), 32'd1);
        rd_tag = "R9";
        run_i = 1'b0;
        step(5);
        finish_run();
    end
endmodule